// File: doc/BRIEF.md
# Stop-Mode Clock Wake Controller

This block sequences a small controller's deepest low-power state. Software must first arm a guard register with a two-byte key. Only then does a write of the stop bit to the control register take effect. Two cycles after an accepted write, the block drops the enables of both the fast and the slow oscillator and closes every clock gate it owns.

A non-maskable interrupt, or a request on any of the port interrupt lines whose enable flag is set, ends the stopped state. Both oscillators are then enabled in the same cycle. Two independent domain timers each count a start-up window of controller cycles, then a fixed number of pulses from their own oscillator. When a timer finishes, it reopens its domain's gates. The fast domain carries the system clock gate and the fast peripheral gate, and the slow domain carries the slow peripheral gate.

Oscillator activity arrives as single-cycle pulse strobes, sampled on an always-running controller clock. A status output reports the current phase, so that the order of events can be watched from outside.

The sequencer moves through five states, with these transitions:
- SEQ_RUN → SEQ_ENTRY1 on an accepted stop write.
- SEQ_ENTRY1 → SEQ_ENTRY2, or SEQ_ENTRY1 → SEQ_RUN on a wake request (cancel).
- SEQ_ENTRY2 → SEQ_STOP, or SEQ_ENTRY2 → SEQ_RUN on a wake request (cancel).
- SEQ_STOP → SEQ_WAKE on a wake request.
- SEQ_WAKE → SEQ_RUN once the fast domain is ready.

Each domain timer has four states, with these transitions:
- TMR_RUN → TMR_OFF on halt.
- TMR_OFF → TMR_START on launch.
- TMR_START → TMR_STAB once the window has elapsed.
- TMR_STAB → TMR_RUN at the last counted pulse.

The key guard has three states: KEY_IDLE, KEY_HALF and KEY_ARMED.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A control-register write (wr_addr = 1, wr_data bit 0 = 1) starts entry only when code_armed is 1. Any control-register write, whatever its data, leaves code_armed at 0 from the next cycle onward.
- R2: code_armed becomes 1 only after two consecutive key-register writes (wr_addr = 0) of 0x5A and then 0xA5. A key write of any other value, or the two values in the other order, leaves it at 0.
- R3: stop_bit reads 1 from the cycle after an accepted write. Two clock edges after that write, phase becomes STOP (1) and both oscillator enables fall.
- R4: While phase is STOP, hs_osc_en, ls_osc_en and all three gate enables are 0.
- R5: The block leaves STOP when nmi_req is 1 or when any port_irq bit is 1 together with the same bit of port_irq_en. A port request whose enable bit is 0 does not wake it.
- R6: At the edge that samples a wake request in STOP, stop_bit returns to 0 and both oscillator enables return to 1 together. phase becomes HS_WAIT (2).
- R7: sysclk_gate_en and hsclk_gate_en reopen HS_START_CYC cycles after the wake edge, plus STAB_PULSES sampled hs_pulse strobes. Pulses inside the start window are not counted.
- R8: lsclk_gate_en reopens independently of the fast domain, LS_START_CYC cycles after the wake edge plus STAB_PULSES sampled ls_pulse strobes. Pulses inside the start window are not counted.
- R9: A wake request sampled during either of the two entry cycles cancels entry. stop_bit returns to 0, phase stays RUN, and the oscillator enables never fall.
- R10: phase encodes RUN = 0, STOP = 1, HS_WAIT = 2 and LS_WAIT = 3. HS_WAIT is shown until the fast gates open, even if the slow gate is already open. LS_WAIT is shown while the fast gates are open and the slow gate is still closed.
- R11: An armed stop write while the slow domain is still settling is ignored, so stop_bit stays 0. It still disarms the guard.
- R12: After reset: phase is RUN, both oscillator enables and all gates are 1, stop_bit is 0 and code_armed is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = key register, 1 = control register |
| wr_data | input | 8 | Write data; bit 0 is the stop bit for control writes |
| nmi_req | input | 1 | Non-maskable wake request |
| port_irq | input | N_PORT_IRQ | Port interrupt request lines |
| port_irq_en | input | N_PORT_IRQ | Per-line wake enable flags |
| hs_pulse | input | 1 | Fast oscillator pulse strobe |
| ls_pulse | input | 1 | Slow oscillator pulse strobe |
| hs_osc_en | output | 1 | Fast oscillator enable |
| ls_osc_en | output | 1 | Slow oscillator enable |
| sysclk_gate_en | output | 1 | System clock gate enable |
| hsclk_gate_en | output | 1 | Fast peripheral clock gate enable |
| lsclk_gate_en | output | 1 | Slow peripheral clock gate enable |
| stop_bit | output | 1 | Current value of the stop bit |
| code_armed | output | 1 | Key guard is armed |
| phase | output | 2 | Current phase, encoded as in R10 |

## Verification
The bench builds the block with HS_START_CYC = 5, LS_START_CYC = 12 and STAB_PULSES = 16. This keeps each wake-up to a few dozen cycles, so every start window and every pulse count can be followed one edge at a time. The short windows also make it cheap to hold one domain's pulses back and force both completion orders. That brings the LS_WAIT phase, the HS_WAIT phase with the slow gate already open, and the armed write during slow settling within reach in a single run. The shipping default of 8192 pulses changes only the counter widths.

// File: rtl/swc_pkg.sv
package swc_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        SEQ_RUN    = 3'd0,
        SEQ_ENTRY1 = 3'd1,
        SEQ_ENTRY2 = 3'd2,
        SEQ_STOP   = 3'd3,
        SEQ_WAKE   = 3'd4
    } seq_state_e;

    // Key guard states
    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    // Per-domain oscillator timer states
    typedef enum logic [1:0] {
        TMR_RUN   = 2'd0,
        TMR_OFF   = 2'd1,
        TMR_START = 2'd2,
        TMR_STAB  = 2'd3
    } tmr_state_e;

    // Externally visible phase code
    localparam logic [1:0] PH_RUN     = 2'd0;
    localparam logic [1:0] PH_STOP    = 2'd1;
    localparam logic [1:0] PH_HS_WAIT = 2'd2;
    localparam logic [1:0] PH_LS_WAIT = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'h5A;
    localparam logic [7:0] KEY_SECOND = 8'hA5;

    localparam logic ADDR_KEY  = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;
    localparam int   STOP_BIT_POS = 0;

    localparam int DOM_HS = 0;
    localparam int DOM_LS = 1;
    localparam int N_DOM  = 2;

endpackage

// File: rtl/swc_unlock.sv
module swc_unlock
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr_i,
    input  logic [7:0] key_data_i,
    input  logic       ctrl_wr_i,
    output logic       armed_o
);

    key_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= KEY_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (ctrl_wr_i) begin
            // every control write consumes the guard
            st_d = KEY_IDLE;
        end else if (key_wr_i) begin
            unique case (st_q)
                KEY_HALF: begin
                    if (key_data_i == KEY_SECOND) begin
                        st_d = KEY_ARMED;
                    end else if (key_data_i == KEY_FIRST) begin
                        st_d = KEY_HALF;
                    end else begin
                        st_d = KEY_IDLE;
                    end
                end
                KEY_IDLE, KEY_ARMED: begin
                    st_d = (key_data_i == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
                end
                default: st_d = KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        armed_o = (st_q == KEY_ARMED);
    end

endmodule

// File: rtl/swc_wake_src.sv
module swc_wake_src #(
    parameter int N_IRQ = 4
) (
    input  logic             nmi_i,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    output logic             wake_o
);

    logic [N_IRQ-1:0] qualified;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign qualified[i] = irq_i[i] & irq_en_i[i];
    end

    assign wake_o = nmi_i | (|qualified);

endmodule

// File: rtl/swc_osc_timer.sv
module swc_osc_timer
    import swc_pkg::*;
#(
    parameter int START_CYC = 64,
    parameter int STAB_CNT  = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic launch_i,
    input  logic pulse_i,
    output logic osc_en_o,
    output logic ready_o
);

    localparam int SW = (START_CYC > 1) ? $clog2(START_CYC) : 1;
    localparam int PW = (STAB_CNT > 1) ? $clog2(STAB_CNT) : 1;
    localparam logic [SW-1:0] S_LAST = SW'(START_CYC - 1);
    localparam logic [PW-1:0] P_LAST = PW'(STAB_CNT - 1);

    tmr_state_e    st_q, st_d;
    logic [SW-1:0] scnt_q;
    logic [PW-1:0] pcnt_q;
    logic          start_end;
    logic          stab_end;

    always_comb begin
        start_end = (st_q == TMR_START) && (scnt_q == S_LAST);
        stab_end  = (st_q == TMR_STAB) && pulse_i && (pcnt_q == P_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TMR_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TMR_RUN:   if (halt_i)    st_d = TMR_OFF;
            TMR_OFF:   if (launch_i)  st_d = TMR_START;
            TMR_START: if (start_end) st_d = TMR_STAB;
            TMR_STAB:  if (stab_end)  st_d = TMR_RUN;
            default:                  st_d = TMR_RUN;
        endcase
    end

    // start window counts controller cycles, stabilization counts strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
            pcnt_q <= '0;
        end else begin
            if (st_q != TMR_START) begin
                scnt_q <= '0;
            end else begin
                scnt_q <= scnt_q + 1'b1;
            end
            if (st_q != TMR_STAB) begin
                pcnt_q <= '0;
            end else if (pulse_i) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        osc_en_o = (st_q != TMR_OFF);
        ready_o  = (st_q == TMR_RUN);
    end

endmodule

// File: rtl/swc_seq.sv
module swc_seq
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req_i,
    input  logic       wake_i,
    input  logic       hs_ready_i,
    input  logic       ls_ready_i,
    output logic       halt_o,
    output logic       launch_o,
    output logic       stop_bit_o,
    output logic [1:0] phase_o
);

    seq_state_e st_q, st_d;
    logic       domains_up;
    logic       accept;

    always_comb begin
        domains_up = hs_ready_i && ls_ready_i;
        accept     = stop_req_i && domains_up &&
                     ((st_q == SEQ_RUN) || (st_q == SEQ_WAKE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_RUN:    if (accept) st_d = SEQ_ENTRY1;
            SEQ_ENTRY1: st_d = wake_i ? SEQ_RUN : SEQ_ENTRY2;
            SEQ_ENTRY2: st_d = wake_i ? SEQ_RUN : SEQ_STOP;
            SEQ_STOP:   if (wake_i) st_d = SEQ_WAKE;
            SEQ_WAKE: begin
                if (accept) begin
                    st_d = SEQ_ENTRY1;
                end else if (hs_ready_i) begin
                    st_d = SEQ_RUN;
                end
            end
            default:    st_d = SEQ_RUN;
        endcase
    end

    always_comb begin
        halt_o     = (st_q == SEQ_ENTRY2) && !wake_i;
        launch_o   = (st_q == SEQ_STOP) && wake_i;
        stop_bit_o = (st_q == SEQ_ENTRY1) || (st_q == SEQ_ENTRY2) ||
                     (st_q == SEQ_STOP);
        unique case (st_q)
            SEQ_STOP: phase_o = PH_STOP;
            SEQ_WAKE: begin
                if (!hs_ready_i) begin
                    phase_o = PH_HS_WAIT;
                end else begin
                    phase_o = ls_ready_i ? PH_RUN : PH_LS_WAIT;
                end
            end
            default:  phase_o = ls_ready_i ? PH_RUN : PH_LS_WAIT;
        endcase
    end

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int N_PORT_IRQ   = 4,
    parameter int HS_START_CYC = 64,
    parameter int LS_START_CYC = 256,
    parameter int STAB_PULSES  = 8192
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  nmi_req,
    input  logic [N_PORT_IRQ-1:0] port_irq,
    input  logic [N_PORT_IRQ-1:0] port_irq_en,
    input  logic                  hs_pulse,
    input  logic                  ls_pulse,
    output logic                  hs_osc_en,
    output logic                  ls_osc_en,
    output logic                  sysclk_gate_en,
    output logic                  hsclk_gate_en,
    output logic                  lsclk_gate_en,
    output logic                  stop_bit,
    output logic                  code_armed,
    output logic [1:0]            phase
);

    logic             key_wr;
    logic             ctrl_wr;
    logic             stop_req;
    logic             wake;
    logic             halt;
    logic             launch;
    logic [N_DOM-1:0] pulse_v;
    logic [N_DOM-1:0] osc_en_v;
    logic [N_DOM-1:0] ready_v;

    always_comb begin
        key_wr   = wr_en && (wr_addr == ADDR_KEY);
        ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
        stop_req = ctrl_wr && wr_data[STOP_BIT_POS] && code_armed;
    end

    swc_unlock u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (key_wr),
        .key_data_i (wr_data),
        .ctrl_wr_i  (ctrl_wr),
        .armed_o    (code_armed)
    );

    swc_wake_src #(.N_IRQ(N_PORT_IRQ)) u_wake (
        .nmi_i    (nmi_req),
        .irq_i    (port_irq),
        .irq_en_i (port_irq_en),
        .wake_o   (wake)
    );

    assign pulse_v[DOM_HS] = hs_pulse;
    assign pulse_v[DOM_LS] = ls_pulse;

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        swc_osc_timer #(
            .START_CYC ((d == DOM_HS) ? HS_START_CYC : LS_START_CYC),
            .STAB_CNT  (STAB_PULSES)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .halt_i   (halt),
            .launch_i (launch),
            .pulse_i  (pulse_v[d]),
            .osc_en_o (osc_en_v[d]),
            .ready_o  (ready_v[d])
        );
    end

    swc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req_i (stop_req),
        .wake_i     (wake),
        .hs_ready_i (ready_v[DOM_HS]),
        .ls_ready_i (ready_v[DOM_LS]),
        .halt_o     (halt),
        .launch_o   (launch),
        .stop_bit_o (stop_bit),
        .phase_o    (phase)
    );

    always_comb begin
        hs_osc_en      = osc_en_v[DOM_HS];
        ls_osc_en      = osc_en_v[DOM_LS];
        sysclk_gate_en = ready_v[DOM_HS];
        hsclk_gate_en  = ready_v[DOM_HS];
        lsclk_gate_en  = ready_v[DOM_LS];
    end

endmodule

// File: rtl/swc_checker.sv
module swc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_addr,
    input logic       nmi_req,
    input logic       hs_osc_en,
    input logic       ls_osc_en,
    input logic       sysclk_gate_en,
    input logic       hsclk_gate_en,
    input logic       lsclk_gate_en,
    input logic       stop_bit,
    input logic       code_armed,
    input logic [1:0] phase
);

    p_ctrl_write_disarms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> !code_armed);

    p_stop_needs_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_bit) |-> $past(code_armed));

    p_entry_two_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && $past(phase) != 2'd1) |-> ($past(stop_bit) && $past(stop_bit, 2)));

    p_stop_bit_in_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> stop_bit);

    p_all_off_in_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> (!hs_osc_en && !ls_osc_en && !sysclk_gate_en &&
                             !hsclk_gate_en && !lsclk_gate_en));

    p_nmi_exits_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && nmi_req) |=> (phase != 2'd1));

    p_wake_reenables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd1 && $past(phase) == 2'd1) |-> (hs_osc_en && ls_osc_en && !stop_bit));

    p_hs_gate_after_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsclk_gate_en) |-> ($past(phase) == 2'd2));

    p_ls_gate_needs_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lsclk_gate_en |-> ls_osc_en);

    p_ls_wait_hs_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |-> (hsclk_gate_en && !lsclk_gate_en));

endmodule

bind stop_wake_ctrl swc_checker u_swc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .nmi_req        (nmi_req),
    .hs_osc_en      (hs_osc_en),
    .ls_osc_en      (ls_osc_en),
    .sysclk_gate_en (sysclk_gate_en),
    .hsclk_gate_en  (hsclk_gate_en),
    .lsclk_gate_en  (lsclk_gate_en),
    .stop_bit       (stop_bit),
    .code_armed     (code_armed),
    .phase          (phase)
);

// File: tb/stop_wake_ctrl_tb_top.sv
module stop_wake_ctrl_tb_top;

    localparam int NIRQ  = 4;
    localparam int HS_ST = 5;
    localparam int LS_ST = 12;
    localparam int STAB  = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic            wr_addr;
    logic [7:0]      wr_data;
    logic            nmi_req;
    logic [NIRQ-1:0] port_irq;
    logic [NIRQ-1:0] port_irq_en;
    logic            hs_pulse;
    logic            ls_pulse;
    logic            hs_osc_en;
    logic            ls_osc_en;
    logic            sysclk_gate_en;
    logic            hsclk_gate_en;
    logic            lsclk_gate_en;
    logic            stop_bit;
    logic            code_armed;
    logic [1:0]      phase;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stop_wake_ctrl #(
        .N_PORT_IRQ   (NIRQ),
        .HS_START_CYC (HS_ST),
        .LS_START_CYC (LS_ST),
        .STAB_PULSES  (STAB)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .nmi_req        (nmi_req),
        .port_irq       (port_irq),
        .port_irq_en    (port_irq_en),
        .hs_pulse       (hs_pulse),
        .ls_pulse       (ls_pulse),
        .hs_osc_en      (hs_osc_en),
        .ls_osc_en      (ls_osc_en),
        .sysclk_gate_en (sysclk_gate_en),
        .hsclk_gate_en  (hsclk_gate_en),
        .lsclk_gate_en  (lsclk_gate_en),
        .stop_bit       (stop_bit),
        .code_armed     (code_armed),
        .phase          (phase)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [1:0] exp_phase(input bit hs_done, input bit ls_done);
        if (!hs_done) return 2'd2;
        if (!ls_done) return 2'd3;
        return 2'd0;
    endfunction

    // called at a falling edge; returns at the falling edge after the sampling edge
    task automatic do_write(input logic a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic arm();
        do_write(1'b0, 8'h5A);
        do_write(1'b0, 8'hA5);
    endtask

    task automatic enter_stop();
        arm();
        check("R2", "armed before entry", 32'(code_armed), 32'd1);
        do_write(1'b1, 8'h01);
        check("R3", "stop_bit after write", 32'(stop_bit), 32'd1);
        check("R3", "phase one edge after write", 32'(phase), 32'd0);
        check("R1", "armed after ctrl write", 32'(code_armed), 32'd0);
        @(negedge clk);
        check("R3", "osc still on before second edge", 32'({hs_osc_en, ls_osc_en}), 32'd3);
        @(negedge clk);
        check("R3", "phase STOP after two edges", 32'(phase), 32'd1);
        check("R4", "osc enables in STOP", 32'({hs_osc_en, ls_osc_en}), 32'd0);
        check("R4", "gates in STOP",
              32'({sysclk_gate_en, hsclk_gate_en, lsclk_gate_en}), 32'd0);
    endtask

    // mode 0: both strobes random; 1: slow strobes held until fast done;
    // 2: fast strobes held until slow done
    task automatic run_wake(input logic nmi_v, input logic [NIRQ-1:0] port_v,
                            input int mode, input bit try_early);
        int  hs_left = HS_ST;
        int  ls_left = LS_ST;
        int  hs_cnt  = 0;
        int  ls_cnt  = 0;
        bit  hs_done = 1'b0;
        bit  ls_done = 1'b0;
        bit  tried   = 1'b0;
        bit  wrote;
        logic hp, lp;
        nmi_req  = nmi_v;
        port_irq = port_v;
        @(posedge clk);
        @(negedge clk);
        nmi_req  = 1'b0;
        port_irq = '0;
        check("R6", "stop_bit cleared on wake", 32'(stop_bit), 32'd0);
        check("R6", "both osc on together", 32'({hs_osc_en, ls_osc_en}), 32'd3);
        check("R6", "phase HS_WAIT", 32'(phase), 32'd2);
        for (int g = 0; g < 2000; g++) begin
            hp = 1'($urandom % 2);
            lp = 1'(($urandom % 3) == 0);
            if (mode == 1 && !hs_done) lp = 1'b0;
            if (mode == 2 && !ls_done) hp = 1'b0;
            hs_pulse = hp & hs_osc_en;
            ls_pulse = lp & ls_osc_en;
            wrote = 1'b0;
            if (try_early && !tried && hs_done && !ls_done) begin
                wr_en   = 1'b1;
                wr_addr = 1'b1;
                wr_data = 8'h01;
                tried   = 1'b1;
                wrote   = 1'b1;
            end
            @(posedge clk);
            if (hs_left > 0) hs_left--;
            else if (hs_cnt < STAB && hp) hs_cnt++;
            if (ls_left > 0) ls_left--;
            else if (ls_cnt < STAB && lp) ls_cnt++;
            hs_done = (hs_cnt == STAB);
            ls_done = (ls_cnt == STAB);
            @(negedge clk);
            wr_en = 1'b0;
            check("R7", "fast gates", 32'({sysclk_gate_en, hsclk_gate_en}),
                  hs_done ? 32'd3 : 32'd0);
            check("R8", "slow gate", 32'(lsclk_gate_en), 32'(ls_done));
            check("R10", "phase during wake", 32'(phase), 32'(exp_phase(hs_done, ls_done)));
            if (wrote) begin
                check("R11", "stop write ignored while slow settling", 32'(stop_bit), 32'd0);
                check("R1", "guard disarmed by ignored write", 32'(code_armed), 32'd0);
            end
            if (hs_done && ls_done) break;
        end
        hs_pulse = 1'b0;
        ls_pulse = 1'b0;
        check("R7", "wake sequence completed", 32'({hs_done, ls_done}), 32'd3);
        if (try_early) check("R11", "early write attempted", 32'(tried), 32'd1);
    endtask

    task automatic cancel_entry(input int at);
        arm();
        do_write(1'b1, 8'h01);
        if (at == 2) begin
            @(negedge clk);
            check("R9", "osc on in second entry cycle", 32'({hs_osc_en, ls_osc_en}), 32'd3);
        end
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
        check("R9", "stop_bit cleared by cancel", 32'(stop_bit), 32'd0);
        check("R9", "phase RUN after cancel", 32'(phase), 32'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9", "osc never stopped", 32'({hs_osc_en, ls_osc_en}), 32'd3);
            check("R9", "phase stays RUN", 32'(phase), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] b0, b1;
        int k;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        nmi_req = 1'b0; port_irq = '0; port_irq_en = '0;
        hs_pulse = 1'b0; ls_pulse = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check("R12", "phase", 32'(phase), 32'd0);
        check("R12", "osc enables", 32'({hs_osc_en, ls_osc_en}), 32'd3);
        check("R12", "gates", 32'({sysclk_gate_en, hsclk_gate_en, lsclk_gate_en}), 32'd7);
        check("R12", "stop_bit", 32'(stop_bit), 32'd0);
        check("R12", "armed", 32'(code_armed), 32'd0);

        // R1 unarmed stop write
        do_write(1'b1, 8'h01);
        check("R1", "unarmed write stop_bit", 32'(stop_bit), 32'd0);
        repeat (3) @(negedge clk);
        check("R1", "unarmed write phase", 32'(phase), 32'd0);
        check("R1", "unarmed write osc", 32'({hs_osc_en, ls_osc_en}), 32'd3);

        // R2 directed key orderings
        do_write(1'b0, 8'hA5);
        do_write(1'b0, 8'h5A);
        check("R2", "reversed order", 32'(code_armed), 32'd0);
        do_write(1'b0, 8'h5A);
        do_write(1'b0, 8'hA5);
        check("R2", "repeated first byte then second", 32'(code_armed), 32'd1);
        do_write(1'b0, 8'h3C);
        check("R2", "other key value drops guard", 32'(code_armed), 32'd0);

        // R2 random key pairs
        for (int i = 0; i < 16; i++) begin
            b0 = ($urandom % 2) ? 8'h5A : 8'($urandom);
            b1 = ($urandom % 2) ? 8'hA5 : 8'($urandom);
            do_write(1'b1, 8'h00);
            do_write(1'b0, b0);
            do_write(1'b0, b1);
            check("R2", "random pair", 32'(code_armed),
                  32'((b0 == 8'h5A) && (b1 == 8'hA5)));
        end

        // R1 control write disarms
        arm();
        do_write(1'b1, 8'h00);
        check("R1", "data-0 ctrl write disarms", 32'(code_armed), 32'd0);
        do_write(1'b1, 8'h01);
        check("R1", "stop after disarm ignored", 32'(stop_bit), 32'd0);
        repeat (3) @(negedge clk);
        check("R1", "phase after ignored stop", 32'(phase), 32'd0);

        // R3/R4/R5: entry, disabled port line, wake on enabled line
        port_irq_en = 4'b1011;
        enter_stop();
        port_irq = 4'b0100;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R5", "masked line keeps STOP", 32'(phase), 32'd1);
            check("R4", "osc off while stopped", 32'({hs_osc_en, ls_osc_en}), 32'd0);
        end
        port_irq = '0;
        run_wake(1'b0, 4'b1000, 0, 1'b0);

        // R10: slow domain done first, phase must stay HS_WAIT
        enter_stop();
        run_wake(1'b1, 4'b0000, 2, 1'b0);

        // R11: armed write while slow domain still settling
        enter_stop();
        arm();
        run_wake(1'b0, 4'b0001, 1, 1'b1);

        // R9 cancellation in each entry cycle
        cancel_entry(1);
        cancel_entry(2);

        // random dwell and wake source
        for (int i = 0; i < 4; i++) begin
            enter_stop();
            repeat ($urandom % 8) @(negedge clk);
            check("R4", "still stopped after dwell", 32'(phase), 32'd1);
            if ($urandom % 2) begin
                run_wake(1'b1, 4'b0000, 0, 1'b0);
            end else begin
                k = $urandom % 3;
                run_wake(1'b0, (k == 2) ? 4'b1000 : (4'b0001 << k), 0, 1'b0);
            end
        end

        repeat (2) @(negedge clk);
        report();
    end

endmodule